// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

The block divides a fast input clock by an integer N from 1 to 8. It produces a one-cycle clock-enable pulse once every N input cycles. It also produces a phase level that works as the divided clock waveform. A configuration word sets the ratio, a resync enable, a one-shot mode and a duty-cycle-stabiliser enable flag. The word is latched when a write strobe is high.

An asynchronous alignment pin lets several dividers restart together. It is brought into the clock domain and edge-detected. A valid rising edge returns the counter to its starting state, so every divider that sees the same edge then ticks on the same input cycles. In one-shot mode only the first edge after a configuration write is honoured. The armed flag shows whether that edge is still awaited.

There is no data stream in this block. All ports are plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `resync_clk_div`

## Requirements
- R1: With `cfg_div_i` = s latched, the divide ratio is N = s+1. `tick_o` is high for exactly one cycle in every N input cycles, so with N = 1 it is high every cycle.
- R2: The alignment pin passes through a two-flop synchroniser, and only its rising edge counts. Suppose the pin rises before clock edge k. The counter restarts at edge k+2, so `tick_o` is high in the cycle after edge k+2. Holding the pin high causes no further restarts.
- R3: A valid alignment edge sets the counter to zero. In the next cycle `tick_o` and `phase_o` are both high, and the following tick comes N cycles later.
- R4: With the resync enable bit (`cfg_sync_en_i` as latched) at 0, alignment edges have no effect on the tick timing.
- R5: A write with both resync enable and one-shot set raises `armed_o` in the next cycle. The first valid edge restarts the counter and clears `armed_o`. Later edges are ignored until the next such write.
- R6: With resync enabled and one-shot clear, every rising edge of the alignment pin restarts the counter.
- R7: A new ratio takes effect only when the counter next wraps. The period running when the write occurs completes at the old length.
- R8: For N >= 2, `phase_o` is high for floor(N/2) cycles of each period, starting at the tick. For N = 1 it stays high.
- R9: After reset the ratio is 1, resync and one-shot are off, `armed_o` is 0 and `dcs_en_o` is 1. In the first cycle after reset, `tick_o` and `phase_o` are high. A write updates `dcs_en_o` from `cfg_dcs_en_i`.
- R10: Two instances with the same ratio that receive a common alignment edge produce identical `tick_o` sequences afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_div_i | input | RATIO_W | Ratio select, N = value + 1 |
| cfg_sync_en_i | input | 1 | Resync enable bit |
| cfg_one_shot_i | input | 1 | 1: first edge after write only; 0: every edge |
| cfg_dcs_en_i | input | 1 | Duty-cycle stabiliser enable bit |
| sync_pin_i | input | 1 | Asynchronous alignment pin |
| tick_o | output | 1 | One-cycle enable at the start of each divided period |
| phase_o | output | 1 | Divided clock level |
| armed_o | output | 1 | One-shot alignment still awaited |
| dcs_en_o | output | 1 | Latched stabiliser enable bit |

## Verification
The bench builds the block with its defaults: a 3-bit ratio select and a two-stage synchroniser. That puts every ratio from 1 to 8 within reach, including odd high-time rounding and the always-high divide-by-1 case. The default synchroniser depth fixes the restart at three samples after the pin is driven. The bench builds a second instance with its own alignment pin. This lets it first push the two dividers out of step and then show that a common edge brings them back in line.

// File: rtl/resync_clk_div_pkg.sv
package resync_clk_div_pkg;

  typedef struct packed {
    logic sync_en;
    logic one_shot;
    logic dcs_en;
  } cfg_flags_t;

  localparam cfg_flags_t FLAGS_RESET = '{sync_en: 1'b0, one_shot: 1'b0, dcs_en: 1'b1};

endpackage

// File: rtl/resync_edge_sync.sv
module resync_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  AST_SINGLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2

endmodule

// File: rtl/resync_ctrl.sv
module resync_ctrl
  import resync_clk_div_pkg::*;
#(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [RATIO_W-1:0] div_i,
  input  cfg_flags_t         flags_i,
  input  logic               rise_i,
  output logic [RATIO_W-1:0] div_q_o,
  output cfg_flags_t         flags_q_o,
  output logic               armed_o,
  output logic               fire_o
);

  logic [RATIO_W-1:0] div_q;
  cfg_flags_t         flags_q;
  logic               armed_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_q   <= '0;
      flags_q <= FLAGS_RESET;
    end else if (wr_i) begin
      div_q   <= div_i;
      flags_q <= flags_i;
    end
  end

  assign fire_o = flags_q.sync_en & rise_i & (~flags_q.one_shot | armed_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (wr_i) begin
      armed_q <= flags_i.sync_en & flags_i.one_shot;
    end else if (fire_o && flags_q.one_shot) begin
      armed_q <= 1'b0;
    end
  end

  assign div_q_o   = div_q;
  assign flags_q_o = flags_q;
  assign armed_o   = armed_q;

  AST_ARM_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> armed_o == $past(flags_i.sync_en && flags_i.one_shot)); // R5

  AST_DISARM_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && flags_q.one_shot && !wr_i) |=> !armed_o); // R5

  AST_NO_FIRE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !flags_q.sync_en) |-> !fire_o); // R4

endmodule

// File: rtl/resync_div_core.sv
module resync_div_core #(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] div_sel_i,
  input  logic               restart_i,
  output logic               tick_o,
  output logic               phase_o
);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] active_q;
  logic               at_wrap;
  logic [RATIO_W:0]   ratio_n;
  logic [RATIO_W:0]   half_n;
  logic [RATIO_W:0]   high_lim;

  assign at_wrap = (cnt_q == active_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= '0;
    end else if (restart_i || at_wrap) begin
      cnt_q    <= '0;
      active_q <= div_sel_i;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    ratio_n  = {1'b0, active_q} + 1'b1;
    half_n   = ratio_n >> 1;
    high_lim = (half_n == '0) ? {{RATIO_W{1'b0}}, 1'b1} : half_n;
  end

  assign tick_o  = (cnt_q == '0);
  assign phase_o = ({1'b0, cnt_q} < high_lim);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= active_q); // R1

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_wrap && !restart_i) |=> cnt_q == $past(cnt_q) + 1'b1); // R1

  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (tick_o && phase_o)); // R3

  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_wrap && !restart_i) |=> $stable(active_q)); // R7

endmodule

// File: rtl/resync_clk_div.sv
module resync_clk_div
  import resync_clk_div_pkg::*;
#(
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [RATIO_W-1:0] cfg_div_i,
  input  logic               cfg_sync_en_i,
  input  logic               cfg_one_shot_i,
  input  logic               cfg_dcs_en_i,
  input  logic               sync_pin_i,
  output logic               tick_o,
  output logic               phase_o,
  output logic               armed_o,
  output logic               dcs_en_o
);

  cfg_flags_t         wr_flags;
  cfg_flags_t         flags_q;
  logic [RATIO_W-1:0] div_q;
  logic               rise;
  logic               fire;

  assign wr_flags = '{sync_en: cfg_sync_en_i, one_shot: cfg_one_shot_i, dcs_en: cfg_dcs_en_i};

  resync_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (sync_pin_i),
    .rise_o (rise)
  );

  resync_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr_i),
    .div_i     (cfg_div_i),
    .flags_i   (wr_flags),
    .rise_i    (rise),
    .div_q_o   (div_q),
    .flags_q_o (flags_q),
    .armed_o   (armed_o),
    .fire_o    (fire)
  );

  resync_div_core #(.RATIO_W(RATIO_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_sel_i (div_q),
    .restart_i (fire),
    .tick_o    (tick_o),
    .phase_o   (phase_o)
  );

  assign dcs_en_o = flags_q.dcs_en;

  AST_TICK_HIGH_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> phase_o); // R8

  AST_DCS_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> dcs_en_o == $past(cfg_dcs_en_i)); // R9

endmodule

// File: tb/resync_clk_div_bench.sv
module resync_clk_div_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_b_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] div = 3'd0;
  logic       s_en = 1'b0;
  logic       one = 1'b0;
  logic       dcs = 1'b1;
  logic       sync_a = 1'b0;
  logic       sync_b = 1'b0;
  logic       tick, phase, armed, dcs_q;
  logic       tick_b, phase_b, armed_b, dcs_b;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  resync_clk_div u_resync_clk_div (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_div_i(div),
    .cfg_sync_en_i(s_en), .cfg_one_shot_i(one), .cfg_dcs_en_i(dcs),
    .sync_pin_i(sync_a), .tick_o(tick), .phase_o(phase),
    .armed_o(armed), .dcs_en_o(dcs_q)
  );

  resync_clk_div u_resync_clk_div_b (
    .clk_i(clk), .rst_ni(rst_b_n), .cfg_wr_i(wr), .cfg_div_i(div),
    .cfg_sync_en_i(s_en), .cfg_one_shot_i(one), .cfg_dcs_en_i(dcs),
    .sync_pin_i(sync_b), .tick_o(tick_b), .phase_o(phase_b),
    .armed_o(armed_b), .dcs_en_o(dcs_b)
  );

  // {select, period, phase-high cycles}
  localparam logic [11:0] VEC [8] = '{
    {4'd0, 4'd1, 4'd1}, {4'd1, 4'd2, 4'd1}, {4'd2, 4'd3, 4'd1}, {4'd3, 4'd4, 4'd2},
    {4'd4, 4'd5, 4'd2}, {4'd5, 4'd6, 4'd3}, {4'd6, 4'd7, 4'd3}, {4'd7, 4'd8, 4'd4}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] s, input logic en, input logic os, input logic d);
    div = s; s_en = en; one = os; dcs = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 40 && !tick; i++) step();
  endtask

  task automatic count_to_tick(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!tick && n < 40);
  endtask

  task automatic measure(output int per, output int hi);
    wait_tick();
    per = 0;
    hi = 0;
    do begin
      hi += int'(phase);
      step();
      per++;
    end while (!tick && per < 40);
  endtask

  task automatic sync_from_tick(output int n);
    wait_tick();
    sync_a = 1'b1;
    count_to_tick(n);
    sync_a = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p, h, n, mism;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    rst_b_n = 1'b1;
    // R9 reset state
    check("R9 tick", int'(tick), 1);
    check("R9 phase", int'(phase), 1);
    check("R9 armed", int'(armed), 0);
    check("R9 dcs", int'(dcs_q), 1);
    measure(p, h);
    check("R9 reset ratio 1", p, 1);

    // R1 / R8 table of ratios
    for (int i = 0; i < 8; i++) begin
      write_cfg(VEC[i][10:8], 1'b0, 1'b0, 1'b1);
      measure(p, h);
      measure(p, h);
      check($sformatf("R1 period sel=%0d", i), p, int'(VEC[i][7:4]));
      check($sformatf("R8 high sel=%0d", i), h, int'(VEC[i][3:0]));
    end

    // R7 ratio change mid-period, ratio 8 active
    wait_tick();
    write_cfg(3'd2, 1'b0, 1'b0, 1'b1);
    count_to_tick(n);
    check("R7 old period completes", n + 1, 8);
    measure(p, h);
    check("R7 new period", p, 3);
    write_cfg(3'd7, 1'b0, 1'b0, 1'b1);
    measure(p, h);
    measure(p, h);
    check("R7 back to 8", p, 8);

    // R4 resync disabled
    sync_from_tick(n);
    check("R4 edge ignored", n, 8);
    check("R4 armed", int'(armed), 0);
    repeat (4) step();

    // R6 / R2 / R3 every-edge mode
    write_cfg(3'd7, 1'b1, 1'b0, 1'b1);
    measure(p, h);
    sync_from_tick(n);
    check("R2 restart latency", n, 3);
    check("R3 phase high at restart", int'(phase), 1);
    measure(p, h);
    check("R3 period after restart", p, 8);
    check("R2 held level no retrigger", h, 4);
    sync_from_tick(n);
    check("R6 second edge restarts", n, 3);
    repeat (4) step();

    // R5 one-shot mode
    write_cfg(3'd7, 1'b1, 1'b1, 1'b1);
    check("R5 armed after write", int'(armed), 1);
    measure(p, h);
    sync_from_tick(n);
    check("R5 first edge restarts", n, 3);
    check("R5 disarmed", int'(armed), 0);
    repeat (4) step();
    sync_from_tick(n);
    check("R5 later edge ignored", n, 8);
    repeat (4) step();
    write_cfg(3'd7, 1'b1, 1'b1, 1'b1);
    check("R5 rearmed", int'(armed), 1);
    sync_from_tick(n);
    check("R5 rearmed edge restarts", n, 3);

    // R9 stabiliser bit write
    write_cfg(3'd7, 1'b1, 1'b0, 1'b0);
    check("R9 dcs cleared", int'(dcs_q), 0);
    write_cfg(3'd7, 1'b1, 1'b0, 1'b1);
    check("R9 dcs set", int'(dcs_q), 1);

    // R10 alignment of two instances
    measure(p, h);
    wait_tick();
    step();
    sync_b = 1'b1;
    repeat (4) step();
    sync_b = 1'b0;
    repeat (4) step();
    mism = 0;
    for (int i = 0; i < 16; i++) begin
      if (tick != tick_b) mism++;
      step();
    end
    check("R10 misaligned before common edge", int'(mism > 0), 1);
    sync_a = 1'b1;
    sync_b = 1'b1;
    repeat (4) step();
    sync_a = 1'b0;
    sync_b = 1'b0;
    mism = 0;
    for (int i = 0; i < 24; i++) begin
      if (tick != tick_b) mism++;
      step();
    end
    check("R10 aligned after common edge", mism, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule